// File: doc/BRIEF.md
# Daisy-Chained Parallel Random Bit Generator

The block turns two shared pseudo-random sources into a wide vector of random bit streams. One 15-bit linear feedback shift register (the broadcast source) feeds its current bit to every output at once. A second 17-bit register (the travelling source) sends its bit through a chain of single-bit delay stages. Each client position in the chain owns a fixed number of these stages, one per stream it needs, and passes the last delayed bit to the next client. Each output stream is the broadcast bit XORed with the delayed travelling bit at that stream's position in the chain.

The two feedback polynomials are primitive and differ, so the streams are copies of one long sequence. Neighbouring streams are shifted from each other by at least the broadcast period. Clients can be added, or given more streams, just by making the chain longer. No tap or seed has to be recomputed. Between stages only the broadcast bit and the travelling bit are routed. A synchronous reset loads both seeds. A common enable advances every register together, so the streams keep their alignment.

Top module: `rand_stream_chain`

## Requirements
- R1: While `rst` is high at a clock edge, the broadcast register loads `seed_r` and the travelling register loads `seed_s`. Every delay stage clears to 0, so after that edge each output bit equals bit 0 of the loaded broadcast state.
- R2: A seed of zero is replaced on load by a fixed non-zero value: 15'h6B5D for the broadcast register and 17'h12F3B for the travelling register. Neither register ever holds zero.
- R3: The broadcast register `r` shifts toward bit 0 on each enabled edge. Its output bit is `r[0]`, and the bit entering at position 14 is `r[0] ^ r[1]` (polynomial x^15 + x + 1).
- R4: The travelling register `s` shifts toward bit 0 on each enabled edge. Its output bit is `s[0]`, and the bit entering at position 16 is `s[0] ^ s[3]` (polynomial x^17 + x^3 + 1).
- R5: Output bit k equals the present broadcast bit XOR the travelling bit as it stood k+1 enabled edges earlier. That value is 0 if fewer than k+1 enabled edges have occurred since reset.
- R6: On an edge with `en` low and `rst` low, no register changes and the output vector holds.
- R7: Stream j of client c appears at output index c*STREAMS + j. Client c+1's chain segment continues from the last stage of client c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset and seed load, active high |
| en | input | 1 | Advance both sources and all delay stages |
| seed_r | input | 15 | Seed for the broadcast register |
| seed_s | input | 17 | Seed for the travelling register |
| bits | output | CLIENTS*STREAMS | Random output streams, one bit each |

## Verification
The assertions assume that `rst` is held high for the first edge and that `en` is a clean level at each edge. The assertions that look back one cycle are used only after a cycle in which reset was low. The bench raises reset before any other stimulus. It changes `rst`, `en` and the seeds only on the falling clock edge. After each reset it rebuilds its model from the seeds, including the zero-seed substitution, so the model and the design start every sequence from the same state.

// File: rtl/rand_stream_chain.sv
module rand_stream_chain #(
  parameter int CLIENTS = 4,
  parameter int STREAMS = 3,
  parameter logic [14:0] R_FALLBACK = 15'h6B5D,
  parameter logic [16:0] S_FALLBACK = 17'h12F3B
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [14:0]                  seed_r,
  input  logic [16:0]                  seed_s,
  output logic [CLIENTS*STREAMS-1:0]   bits
);
  localparam int NSTR = CLIENTS * STREAMS;

  logic [14:0] r_q;
  logic [16:0] s_q;
  logic        r_bit;
  logic [CLIENTS:0] hop;

  assign r_bit  = r_q[0];
  assign hop[0] = s_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q <= (seed_r == '0) ? R_FALLBACK : seed_r;
      s_q <= (seed_s == '0) ? S_FALLBACK : seed_s;
    end else if (en) begin
      r_q <= {r_q[0] ^ r_q[1], r_q[14:1]};
      s_q <= {s_q[0] ^ s_q[3], s_q[16:1]};
    end
  end

  for (genvar c = 0; c < CLIENTS; c++) begin : g_client
    logic [STREAMS-1:0] dly;
    always_ff @(posedge clk) begin
      if (rst)     dly <= '0;
      else if (en) dly <= {dly[STREAMS-2:0], hop[c]};
    end
    assign hop[c+1] = dly[STREAMS-1];
    for (genvar j = 0; j < STREAMS; j++) begin : g_out
      assign bits[c*STREAMS + j] = r_bit ^ dly[j];
    end
  end
endmodule

module rand_stream_chain_chk #(
  parameter int NSTR = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [14:0]     r_q,
  input logic [16:0]     s_q,
  input logic [NSTR-1:0] bits
);
  p_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    (r_q != '0) && (s_q != '0));
  p_rstep_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> r_q[13:0] == $past(r_q[14:1]));
  p_sstep_r4: assert property (@(posedge clk) disable iff (rst)
    en |=> s_q[15:0] == $past(s_q[16:1]));
  p_head_r5: assert property (@(posedge clk) disable iff (rst)
    en |=> (bits[0] ^ r_q[0]) == $past(s_q[0]));
  for (genvar k = 1; k < NSTR; k++) begin : g_link
    p_link_r7: assert property (@(posedge clk) disable iff (rst)
      en |=> (bits[k] ^ r_q[0]) == $past(bits[k-1] ^ r_q[0]));
  end
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(bits) && $stable(r_q) && $stable(s_q));
endmodule

bind rand_stream_chain rand_stream_chain_chk #(.NSTR(CLIENTS*STREAMS)) u_chk (
  .clk(clk), .rst(rst), .en(en), .r_q(r_q), .s_q(s_q), .bits(bits)
);

// File: tb/tb_rand_stream_chain.sv
module tb_rand_stream_chain;
  localparam int CLIENTS = 4;
  localparam int STREAMS = 3;
  localparam int NSTR = CLIENTS * STREAMS;
  localparam logic PAT [16] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
                                1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [14:0] seed_r = 15'h1234;
  logic [16:0] seed_s = 17'h0ABCD;
  logic [NSTR-1:0] bits;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  logic [14:0] mr;
  logic [16:0] ms;
  logic [NSTR-1:0] hist;

  always #5 clk = ~clk;

  rand_stream_chain #(.CLIENTS(CLIENTS), .STREAMS(STREAMS)) dut (
    .clk(clk), .rst(rst), .en(en), .seed_r(seed_r), .seed_s(seed_s), .bits(bits)
  );

  function automatic logic [NSTR-1:0] expect_bits();
    logic [NSTR-1:0] e;
    for (int k = 0; k < NSTR; k++) e[k] = mr[0] ^ hist[k];
    return e;
  endfunction

  task automatic check(input string tag);
    logic [NSTR-1:0] e;
    e = expect_bits();
    nvec++;
    if (bits !== e) begin
      nbad++;
      $display("FAIL %s: bits=%h expected=%h", tag, bits, e);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic [14:0] sr,
                      input logic [16:0] ss, input string tag);
    @(negedge clk);
    rst = r; en = e; seed_r = sr; seed_s = ss;
    @(posedge clk);
    if (r) begin
      mr = (sr == '0) ? 15'h6B5D : sr;
      ms = (ss == '0) ? 17'h12F3B : ss;
      hist = '0;
    end else if (e) begin
      hist = {hist[NSTR-2:0], ms[0]};
      mr = {mr[0] ^ mr[1], mr[14:1]};
      ms = {ms[0] ^ ms[3], ms[16:1]};
    end
    #2;
    check(tag);
  endtask

  initial begin
    #(10 * 100000);
    if (!done) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    step(1'b1, 1'b0, 15'h1234, 17'h0ABCD, "R1 reset load");
    step(1'b1, 1'b1, 15'h1235, 17'h0ABCD, "R1 reset over enable");
    for (int i = 0; i < 64; i++)
      step(1'b0, PAT[i % 16], 15'h1235, 17'h0ABCD, "R5 table walk");
    for (int i = 0; i < 6; i++)
      step(1'b0, 1'b0, 15'h7FFF, 17'h1FFFF, "R6 hold");
    step(1'b1, 1'b0, 15'h0000, 17'h0000, "R2 zero seeds");
    for (int i = 0; i < 20; i++)
      step(1'b0, 1'b1, 15'h0, 17'h0, "R2 run after zero seed");
    step(1'b1, 1'b0, 15'h0000, 17'h00001, "R2 zero broadcast seed only");
    step(1'b1, 1'b0, 15'h4001, 17'h00000, "R2 zero travelling seed only");
    for (int i = 0; i < 300; i++)
      step(1'b0, 1'b1, 15'h0, 17'h0, "R3 R4 long run");
    begin
      int idx;
      idx = 2 * STREAMS + 1;
      nvec++;
      if (bits[idx] !== (mr[0] ^ hist[idx])) begin
        nbad++;
        $display("FAIL R7: bit%0d=%b expected=%b", idx, bits[idx], mr[0] ^ hist[idx]);
      end
    end
    step(1'b1, 1'b1, 15'h5A5A, 17'h1C3C3, "R1 mid-run reset");
    for (int i = 0; i < 40; i++)
      step(1'b0, PAT[(i * 3) % 16], 15'h0, 17'h0, "R7 chain across clients");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule